// File: doc/BRIEF.md
# Processor System Register File

This block keeps the control and status registers of a processor core. Software reaches each of them through a 5-bit register number. A read returns the selected register on `sw_rdata` in the same cycle. A write takes effect at the next clock edge.

The core also signals events to the block. When it takes an interrupt, a non-maskable interrupt, a table call or a debug trap, it raises an entry strobe with the event class, the current PC, the current PSW and a cause code. The block stores the PC and PSW in the save pair that belongs to that class, and it loads the cause register. Each class has exactly one save pair, so a nested entry of the same class overwrites the earlier values.

On a return, the core picks a class with `ret_sel`. The block then drives the saved PC and PSW of that class as the restore values.

The block has no sequencing of its own. It is plain register state with a single update edge per cycle, so it contains no state machine.

Top module: `sysreg_file`

## Requirements
- R1: After reset, every save register and the cause register read 0. The table-call base register (number 20) also reads 0. The PSW (number 5) reads the parameter `PSW_RESET`.
- R2: A software write to any of the numbers 0, 1, 2, 3, 5, 16, 17, 18, 19 or 20 stores `sw_wdata` at the clock edge. A later read of the same number returns that value.
- R3: The cause register is number 4. Software can read it, but a software write to it leaves its value unchanged.
- R4: Numbers 6 to 15 and 21 to 31 are reserved. A read of a reserved number returns 0. A write to a reserved number changes no register.
- R5: On an entry strobe, `ev_pc` and `ev_psw` are stored in one save pair, chosen by `ev_class`:
  - class 0 (interrupt) stores into registers 0 and 1;
  - class 1 (non-maskable interrupt) stores into registers 2 and 3;
  - class 2 (table call) stores into registers 16 and 17;
  - class 3 (debug trap) stores into registers 18 and 19.

  The other save pairs keep their values.
- R6: Every entry strobe loads `ev_cause` into register 4.
- R7: A second entry of the same class overwrites the values saved by the first entry.
- R8: An entry strobe and a software write may target the same register in the same cycle. In that case the register takes the value from the entry strobe. A software write in the same cycle to a different register still takes effect.
- R9: For `ret_sel` values 0, 1 and 2 (interrupt, non-maskable interrupt, table call), `ret_pc` is the saved PC of that class with bit 0 forced to 0, and `ret_psw` is the saved PSW of that class.
- R10: For `ret_sel` value 3 (debug trap), `ret_pc` is the saved PC unchanged, including bit 0, and `ret_psw` is the saved PSW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_we | input | 1 | Software write strobe |
| sw_num | input | 5 | Register number for the software read and write |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Value of the selected register; 0 for a reserved number |
| ev_valid | input | 1 | Event entry strobe |
| ev_class | input | 2 | Event class: 0 interrupt, 1 non-maskable interrupt, 2 table call, 3 debug trap |
| ev_pc | input | 32 | PC to save on entry |
| ev_psw | input | 32 | PSW to save on entry |
| ev_cause | input | 32 | Cause code loaded on entry |
| ret_sel | input | 2 | Class whose saved values are restored |
| ret_pc | output | 32 | Restore PC |
| ret_psw | output | 32 | Restore PSW |

## Verification
A software write and a hardware entry capture can fall in the same cycle. The capture and a return read can also fall in the same cycle.

The bench provokes the first collision in two ways. It writes the very register that the entry strobe loads, and it writes a register that the strobe does not touch. It then reads both registers back.

In every cycle, a behavioural register model in the bench predicts the read and restore outputs. The model applies the software write first and the capture second, so its result encodes capture priority. The outputs are judged against that prediction.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int NUM_W = 5;
    localparam int NREGS = 1 << NUM_W;

    typedef enum logic [1:0] {
        EV_INT   = 2'd0,
        EV_NMI   = 2'd1,
        EV_TCALL = 2'd2,
        EV_DBG   = 2'd3
    } ev_class_e;

    localparam logic [NUM_W-1:0] RN_INT_PC   = 5'd0;
    localparam logic [NUM_W-1:0] RN_INT_PSW  = 5'd1;
    localparam logic [NUM_W-1:0] RN_NMI_PC   = 5'd2;
    localparam logic [NUM_W-1:0] RN_NMI_PSW  = 5'd3;
    localparam logic [NUM_W-1:0] RN_CAUSE    = 5'd4;
    localparam logic [NUM_W-1:0] RN_PSW      = 5'd5;
    localparam logic [NUM_W-1:0] RN_TC_PC    = 5'd16;
    localparam logic [NUM_W-1:0] RN_TC_PSW   = 5'd17;
    localparam logic [NUM_W-1:0] RN_DBG_PC   = 5'd18;
    localparam logic [NUM_W-1:0] RN_DBG_PSW  = 5'd19;
    localparam logic [NUM_W-1:0] RN_TC_BASE  = 5'd20;

    // Register number of the PC half of each class's save pair; PSW half is +1.
    function automatic logic [NUM_W-1:0] pair_pc_num(input logic [1:0] cls);
        logic [NUM_W-1:0] n;
        unique case (cls)
            EV_INT:   n = RN_INT_PC;
            EV_NMI:   n = RN_NMI_PC;
            EV_TCALL: n = RN_TC_PC;
            default:  n = RN_DBG_PC;
        endcase
        return n;
    endfunction

    function automatic logic num_defined(input logic [NUM_W-1:0] n);
        return (n <= RN_PSW) || ((n >= RN_TC_PC) && (n <= RN_TC_BASE));
    endfunction

    function automatic logic num_writable(input logic [NUM_W-1:0] n);
        return num_defined(n) && (n != RN_CAUSE);
    endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
    import sysreg_pkg::*;
(
    input  logic             sw_we,
    input  logic [NUM_W-1:0] sw_num,
    output logic [NREGS-1:0] we_vec
);

    // One-hot write enable over register numbers; read-only and reserved
    // numbers never produce an enable.
    always_comb begin
        we_vec = '0;
        if (sw_we && num_writable(sw_num)) begin
            we_vec[sw_num] = 1'b1;
        end
    end

endmodule

// File: rtl/sysreg_save_pair.sv
module sysreg_save_pair #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we_pc,
    input  logic              sw_we_psw,
    input  logic [DATA_W-1:0] sw_wdata,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_pc,
    input  logic [DATA_W-1:0] cap_psw,
    output logic [DATA_W-1:0] pc_q,
    output logic [DATA_W-1:0] psw_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            psw_q <= '0;
        end else if (cap_en) begin
            pc_q  <= cap_pc;
            psw_q <= cap_psw;
        end else begin
            if (sw_we_pc)  pc_q  <= sw_wdata;
            if (sw_we_psw) psw_q <= sw_wdata;
        end
    end

    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (pc_q == $past(cap_pc)) && (psw_q == $past(cap_psw))); // R8

    AST_SW_LOAD_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we_pc && !cap_en) |=> (pc_q == $past(sw_wdata))); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !sw_we_pc && !sw_we_psw) |=> $stable(pc_q) && $stable(psw_q)); // R5

endmodule

// File: rtl/sysreg_core_regs.sv
module sysreg_core_regs #(
    parameter int          DATA_W    = 32,
    parameter logic [31:0] PSW_RESET = 32'h0000_0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_psw,
    input  logic              we_base,
    input  logic [DATA_W-1:0] sw_wdata,
    input  logic              cause_ld,
    input  logic [DATA_W-1:0] cause_in,
    output logic [DATA_W-1:0] psw_q,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] cause_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psw_q   <= DATA_W'(PSW_RESET);
            base_q  <= '0;
            cause_q <= '0;
        end else begin
            if (we_psw)   psw_q   <= sw_wdata;
            if (we_base)  base_q  <= sw_wdata;
            if (cause_ld) cause_q <= cause_in;
        end
    end

    AST_CAUSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cause_ld |=> (cause_q == $past(cause_in))); // R6

    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_ld |=> $stable(cause_q)); // R3

endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
    import sysreg_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter logic [31:0] PSW_RESET = 32'h0000_0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [4:0]        sw_num,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata,
    input  logic              ev_valid,
    input  logic [1:0]        ev_class,
    input  logic [DATA_W-1:0] ev_pc,
    input  logic [DATA_W-1:0] ev_psw,
    input  logic [DATA_W-1:0] ev_cause,
    input  logic [1:0]        ret_sel,
    output logic [DATA_W-1:0] ret_pc,
    output logic [DATA_W-1:0] ret_psw
);

    localparam int NPAIRS = 4;

    logic [NREGS-1:0]  we_vec;
    logic [DATA_W-1:0] pair_pc  [NPAIRS];
    logic [DATA_W-1:0] pair_psw [NPAIRS];
    logic [DATA_W-1:0] psw_q, base_q, cause_q;

    sysreg_decode u_decode (
        .sw_we  (sw_we),
        .sw_num (sw_num),
        .we_vec (we_vec)
    );

    for (genvar k = 0; k < NPAIRS; k++) begin : g_pair
        localparam logic [NUM_W-1:0] PC_NUM = pair_pc_num(k[1:0]);
        sysreg_save_pair #(.DATA_W(DATA_W)) u_pair (
            .clk       (clk),
            .rst_n     (rst_n),
            .sw_we_pc  (we_vec[PC_NUM]),
            .sw_we_psw (we_vec[PC_NUM + 1]),
            .sw_wdata  (sw_wdata),
            .cap_en    (ev_valid && (ev_class == k[1:0])),
            .cap_pc    (ev_pc),
            .cap_psw   (ev_psw),
            .pc_q      (pair_pc[k]),
            .psw_q     (pair_psw[k])
        );
    end

    sysreg_core_regs #(.DATA_W(DATA_W), .PSW_RESET(PSW_RESET)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_psw   (we_vec[RN_PSW]),
        .we_base  (we_vec[RN_TC_BASE]),
        .sw_wdata (sw_wdata),
        .cause_ld (ev_valid),
        .cause_in (ev_cause),
        .psw_q    (psw_q),
        .base_q   (base_q),
        .cause_q  (cause_q)
    );

    always_comb begin
        unique case (sw_num)
            RN_INT_PC:  sw_rdata = pair_pc[EV_INT];
            RN_INT_PSW: sw_rdata = pair_psw[EV_INT];
            RN_NMI_PC:  sw_rdata = pair_pc[EV_NMI];
            RN_NMI_PSW: sw_rdata = pair_psw[EV_NMI];
            RN_CAUSE:   sw_rdata = cause_q;
            RN_PSW:     sw_rdata = psw_q;
            RN_TC_PC:   sw_rdata = pair_pc[EV_TCALL];
            RN_TC_PSW:  sw_rdata = pair_psw[EV_TCALL];
            RN_DBG_PC:  sw_rdata = pair_pc[EV_DBG];
            RN_DBG_PSW: sw_rdata = pair_psw[EV_DBG];
            RN_TC_BASE: sw_rdata = base_q;
            default:    sw_rdata = '0;
        endcase
    end

    // Only the debug pair returns its PC untouched; the others restore to an even address.
    always_comb begin
        ret_psw = pair_psw[ret_sel];
        if (ret_sel == EV_DBG) begin
            ret_pc = pair_pc[ret_sel];
        end else begin
            ret_pc = {pair_pc[ret_sel][DATA_W-1:1], 1'b0};
        end
    end

    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !num_defined(sw_num) |-> (sw_rdata == '0)); // R4

    AST_CAUSE_SW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && (sw_num == RN_CAUSE) && !ev_valid) |=> $stable(cause_q)); // R3

    AST_RET_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_sel != EV_DBG) |-> !ret_pc[0]); // R9

    AST_RSV_WRITE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !num_defined(sw_num)) |-> (we_vec == '0)); // R4

endmodule

// File: tb/sysreg_file_tb.sv
module sysreg_file_tb;

    localparam logic [31:0] PSW_RST = 32'h0000_0020;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [4:0]  sw_num = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_class = '0;
    logic [31:0] ev_pc = '0, ev_psw = '0, ev_cause = '0;
    logic [1:0]  ret_sel = '0;
    logic [31:0] ret_pc, ret_psw;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    logic [31:0] mdl [32];

    always #2 clk = ~clk;

    sysreg_file #(.DATA_W(32), .PSW_RESET(PSW_RST)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .sw_we(sw_we), .sw_num(sw_num), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .ev_valid(ev_valid), .ev_class(ev_class), .ev_pc(ev_pc), .ev_psw(ev_psw),
        .ev_cause(ev_cause), .ret_sel(ret_sel), .ret_pc(ret_pc), .ret_psw(ret_psw)
    );

    function automatic bit is_def(input int n);
        return (n <= 5) || (n >= 16 && n <= 20);
    endfunction

    function automatic int pc_slot(input int c);
        int tbl [4] = '{0, 2, 16, 18};
        return tbl[c];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
        mdl[5] = PSW_RST;
    endtask

    // Reference model: software write first, then the hardware capture on top.
    always @(posedge clk) begin
        if (rst_n) begin
            if (sw_we && is_def(int'(sw_num)) && sw_num != 5'd4) mdl[sw_num] = sw_wdata;
            if (ev_valid) begin
                mdl[pc_slot(int'(ev_class))]     = ev_pc;
                mdl[pc_slot(int'(ev_class)) + 1] = ev_psw;
                mdl[4] = ev_cause;
            end
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [31:0] e_rd, e_pc;
        int p;
        e_rd = is_def(int'(sw_num)) ? mdl[sw_num] : 32'h0;
        p = pc_slot(int'(ret_sel));
        e_pc = (ret_sel == 2'd3) ? mdl[p] : (mdl[p] & 32'hFFFF_FFFE);
        check("sw_rdata", sw_rdata, e_rd);
        check("ret_pc", ret_pc, e_pc);
        check("ret_psw", ret_psw, mdl[p + 1]);
    endtask

    task automatic step(input bit we, input int num, input logic [31:0] wd,
                        input bit ev, input int cls, input logic [31:0] pc,
                        input logic [31:0] psw, input logic [31:0] cause, input int rs);
        @(negedge clk);
        sw_we = we; sw_num = num[4:0]; sw_wdata = wd;
        ev_valid = ev; ev_class = cls[1:0]; ev_pc = pc; ev_psw = psw; ev_cause = cause;
        ret_sel = rs[1:0];
        #1;
        compare_all();
    endtask

    task automatic rd(input int num, input int rs);
        step(0, num, 32'h0, 0, 0, 32'h0, 32'h0, 32'h0, rs);
    endtask

    task automatic wr(input int num, input logic [31:0] d);
        step(1, num, d, 0, 0, 32'h0, 32'h0, 32'h0, 0);
    endtask

    task automatic ev(input int cls, input logic [31:0] pc, input logic [31:0] psw, input logic [31:0] c);
        step(0, 0, 32'h0, 1, cls, pc, psw, c, 0);
    endtask

    task automatic read_all();
        for (int n = 0; n < 32; n++) rd(n, n % 4);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values of every number
        cur_req = "R1";
        read_all();

        // R2: round trip through every writable number, odd values included
        cur_req = "R2";
        for (int n = 0; n < 32; n++)
            if (is_def(n) && n != 4) wr(n, 32'hA500_0001 + (n << 8));
        read_all();

        // R3: cause register ignores software writes
        cur_req = "R3";
        wr(4, 32'hDEAD_BEEF);
        rd(4, 0);

        // R4: reserved numbers read zero and writes change nothing
        cur_req = "R4";
        for (int n = 6; n < 16; n++) wr(n, 32'hFFFF_FFFF);
        for (int n = 21; n < 32; n++) wr(n, 32'hFFFF_FFFF);
        read_all();

        // R5 / R6: each class captures into its own pair, cause follows
        cur_req = "R5";
        for (int c = 0; c < 4; c++) begin
            ev(c, 32'h1000_0000 + c * 16, 32'h0000_0100 + c, 32'h0000_0010 + c);
            read_all();
        end
        cur_req = "R6";
        ev(2, 32'h2222_0000, 32'h0000_0777, 32'h0000_FACE);
        rd(4, 2);

        // R7: nested entry of the same class overwrites
        cur_req = "R7";
        ev(0, 32'h3000_0000, 32'h11, 32'h90);
        ev(0, 32'h3000_0100, 32'h22, 32'h91);
        rd(0, 0); rd(1, 0); rd(4, 0);

        // R8: same-cycle collision, same register and different register
        cur_req = "R8";
        step(1, 2, 32'h5555_5555, 1, 1, 32'h4000_0000, 32'h33, 32'h92, 1);
        rd(2, 1); rd(3, 1);
        step(1, 20, 32'h6666_6666, 1, 3, 32'h4100_0001, 32'h44, 32'h93, 3);
        rd(20, 3); rd(18, 3); rd(19, 3);

        // R9 / R10: odd PCs written by software, restored per class
        cur_req = "R9";
        wr(0, 32'h7000_0001); wr(2, 32'h7100_0003); wr(16, 32'h7200_0005);
        rd(0, 0); rd(0, 1); rd(0, 2);
        cur_req = "R10";
        wr(18, 32'h7300_0007);
        rd(0, 3);
        ev(3, 32'h7400_0009, 32'h55, 32'h94);
        rd(18, 3);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule